// File: doc/BRIEF.md
# Strobe-Handshake Host Register Interface

This block sits between a host parallel bus and a serial link transceiver. The host addresses one of two registers with a select line. One is a data register: writes go to the transmit path and reads come from the receive path. The other is a combined control and status word. Each access is qualified by a strobe. A `full` output tells the host whether a word is waiting in either direction, so the host can pace its transfers with two wires. The data bus is modelled as separate input, output and output-enable signals. The block drives the bus only while it is serving a read.

The control word holds three configuration bits:

| Bit | Meaning |
|-----|---------|
| 0 | Run. A 0 is an active-low clear that stops all datapath activity. |
| 1 | Width. 1 selects 32-bit words, 0 selects 16-bit words. |
| 2 | Timeout enable. 0 disables the transmit timeout. |

The same word reports three sticky error flags:

| Bit | Flag |
|-----|------|
| 4 | Receive overwrite |
| 5 | Missing half-word |
| 6 | Sync bit missing |

The `host_err` output is high whenever any flag is set. Reset zeroes the control word, so the block starts in clear. The host must write the run bit high before any traffic moves.

Access sequencing uses three states:

| State | Meaning | Leaves for | Condition |
|-------|---------|------------|-----------|
| `ST_IDLE` | Waiting for an access | `ST_WRITE` | Strobe sampled high with `host_rw` low |
| | | `ST_READ` | Strobe sampled high with `host_rw` high |
| `ST_WRITE` | Write committed | `ST_IDLE` | Strobe sampled low |
| `ST_READ` | Driving the bus | `ST_IDLE` | Strobe sampled low |

The register update or read capture happens on the `ST_IDLE` exit edge. A strobe held high therefore performs exactly one access.

Top module: `strobe_reg_if`

## Requirements
- R1: After reset, `host_full`, `host_err`, `host_doe`, `cfg_run`, `cfg_wide` and `cfg_timeout_en` are all 0, and a read of the control word returns 0.
- R2: A write with `host_sel`=0 loads `host_din[2:0]` into run (bit 0), width (bit 1) and timeout enable (bit 2). These appear on the `cfg_*` outputs in the cycle after the edge that samples the strobe. A read with `host_sel`=0 returns the three control bits in bits [2:0].
- R3: With run=1, a write with `host_sel`=1 sets `tx_valid` and `host_full` in the cycle after the strobe edge, with the word on `tx_word`. A `tx_take` pulse clears `tx_valid`.
- R4: With width=0, a data write presents `{16'h0, host_din[15:0]}` on `tx_word`, and a data read returns the upper 16 bits as 0.
- R5: With run=1, an `rx_valid` pulse stores `rx_word` and sets `host_full`. A read with `host_sel`=1 returns that word and clears the pending state.
- R6: `host_doe` rises only in the cycle after a read strobe is sampled. It falls in the cycle after the strobe is sampled low. It never rises for a write.
- R7: An `rx_valid` that arrives while a received word is still unread sets the overwrite flag (control word bit 4) and `host_err`.
- R8: With run=1, `ev_word_miss` sets bit 5 and `ev_sync_err` sets bit 6. `host_err` is the OR of bits 4 to 6.
- R9: While run=0, both pending words are dropped and all flags are cleared. Data writes, `rx_valid` and error events have no effect.
- R10: When `rx_valid` arrives in the same cycle that a data read is sampled, the read returns the older word. The new word stays pending with `host_full` high, and no overwrite flag is set.
- R11: A strobe held high for several cycles performs a single access. A word taken during the hold is not re-queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_sel | input | 1 | 1 = data register, 0 = control/status word |
| host_stb | input | 1 | Access strobe |
| host_din | input | 32 | Write data from host |
| host_dout | output | 32 | Read data to host (0 when not driving) |
| host_doe | output | 1 | Bus drive enable |
| host_full | output | 1 | A transmit or receive word is pending |
| host_err | output | 1 | Any error flag set |
| tx_word | output | 32 | Word for the serializer |
| tx_valid | output | 1 | Transmit word pending |
| tx_take | input | 1 | Serializer has consumed the word |
| rx_word | input | 32 | Word from the deserializer |
| rx_valid | input | 1 | Received word strobe |
| ev_sync_err | input | 1 | Sync-bit-missing event |
| ev_word_miss | input | 1 | Missing-half-word event |
| cfg_run | output | 1 | 0 holds the datapath in clear |
| cfg_wide | output | 1 | 1 = 32-bit, 0 = 16-bit |
| cfg_timeout_en | output | 1 | 0 disables the transmit timeout |

## Verification
Two functions can meet in one cycle: a received word landing in the receive register, and the host read of that register clearing its pending state. The bench raises `rx_valid` in the same cycle that the read strobe is first sampled. It then expects three things: the read returns the older word, `host_full` stays high, and a following read returns the newer word. A final control-word read confirms that the overwrite flag stayed 0. The same pattern with a held write strobe and a `tx_take` pulse checks that one strobe never enqueues twice.

// File: rtl/strobe_reg_if_pkg.sv
`timescale 1ns/1ps
package strobe_reg_if_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } acc_state_t;

    // control bit positions in the host-visible word
    localparam int CTL_RUN  = 0;
    localparam int CTL_WIDE = 1;
    localparam int CTL_TOEN = 2;
    localparam int CTL_BITS = 3;

    // error flags: index into flag vector, placed from FLG_BASE upward
    localparam int FLG_BASE = 4;
    localparam int N_FLAGS  = 3;
    localparam int FLG_OVW  = 0;
    localparam int FLG_MISS = 1;
    localparam int FLG_SYNC = 2;

endpackage

// File: rtl/sri_access_fsm.sv
`timescale 1ns/1ps
module sri_access_fsm
    import strobe_reg_if_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic rw,
    output logic wr_go,
    output logic rd_go,
    output logic drive
);

    acc_state_t st_q;
    acc_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (stb) st_d = rw ? ST_READ : ST_WRITE;
            ST_WRITE: if (!stb) st_d = ST_IDLE;
            ST_READ:  if (!stb) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_go = 1'b0;
        rd_go = 1'b0;
        drive = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                wr_go = stb && !rw;
                rd_go = stb && rw;
            end
            ST_READ:  drive = 1'b1;
            ST_WRITE: drive = 1'b0;
            default:  drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/sri_ctl_regs.sv
`timescale 1ns/1ps
module sri_ctl_regs
    import strobe_reg_if_pkg::*;
#(
    parameter int NF = N_FLAGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctl,
    input  logic [CTL_BITS-1:0] ctl_in,
    input  logic [NF-1:0]       flag_evt,
    output logic                run,
    output logic                wide,
    output logic                toen,
    output logic [NF-1:0]       flags
);

    logic [CTL_BITS-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= ctl_in;
    end

    assign run  = ctl_q[CTL_RUN];
    assign wide = ctl_q[CTL_WIDE];
    assign toen = ctl_q[CTL_TOEN];

    // sticky flags, held clear while the run bit is low
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flags[i] <= 1'b0;
            else if (!run)        flags[i] <= 1'b0;
            else if (flag_evt[i]) flags[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/sri_data_regs.sv
`timescale 1ns/1ps
module sri_data_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wide,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] din,
    input  logic              tx_take,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_in,
    output logic [DATA_W-1:0] tx_q,
    output logic              tx_pend,
    output logic              rx_pend,
    output logic [DATA_W-1:0] rd_word,
    output logic              ovw_evt
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] rx_q;

    assign wmask = wide ? '1 : LO_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            tx_pend <= 1'b0;
        end else if (!run) begin
            tx_pend <= 1'b0;
        end else if (wr_data) begin
            tx_q    <= din & wmask;
            tx_pend <= 1'b1;
        end else if (tx_take) begin
            tx_pend <= 1'b0;
        end
    end

    // arrival outranks the read clearing pending state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_pend <= 1'b0;
        end else if (!run) begin
            rx_pend <= 1'b0;
        end else if (rx_valid) begin
            rx_q    <= rx_in;
            rx_pend <= 1'b1;
        end else if (rd_data) begin
            rx_pend <= 1'b0;
        end
    end

    assign rd_word = rx_q & wmask;
    assign ovw_evt = rx_valid && rx_pend && !rd_data;

endmodule

// File: rtl/strobe_reg_if.sv
`timescale 1ns/1ps
module strobe_reg_if
    import strobe_reg_if_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rw,
    input  logic              host_sel,
    input  logic              host_stb,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_full,
    output logic              host_err,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_valid,
    input  logic              ev_sync_err,
    input  logic              ev_word_miss,
    output logic              cfg_run,
    output logic              cfg_wide,
    output logic              cfg_timeout_en
);

    logic              wr_go, rd_go, drive;
    logic              rx_pend, ovw_evt;
    logic [DATA_W-1:0] rd_word, ctl_word, dout_q;
    logic [N_FLAGS-1:0] flags, flag_evt;

    sri_access_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (host_stb),
        .rw    (host_rw),
        .wr_go (wr_go),
        .rd_go (rd_go),
        .drive (drive)
    );

    always_comb begin
        flag_evt           = '0;
        flag_evt[FLG_OVW]  = ovw_evt;
        flag_evt[FLG_MISS] = ev_word_miss;
        flag_evt[FLG_SYNC] = ev_sync_err;
    end

    sri_ctl_regs #(.NF(N_FLAGS)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_go && !host_sel),
        .ctl_in   (host_din[CTL_BITS-1:0]),
        .flag_evt (flag_evt),
        .run      (cfg_run),
        .wide     (cfg_wide),
        .toen     (cfg_timeout_en),
        .flags    (flags)
    );

    sri_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_run),
        .wide     (cfg_wide),
        .wr_data  (wr_go && host_sel),
        .rd_data  (rd_go && host_sel),
        .din      (host_din),
        .tx_take  (tx_take),
        .rx_valid (rx_valid),
        .rx_in    (rx_word),
        .tx_q     (tx_word),
        .tx_pend  (tx_valid),
        .rx_pend  (rx_pend),
        .rd_word  (rd_word),
        .ovw_evt  (ovw_evt)
    );

    always_comb begin
        ctl_word                       = '0;
        ctl_word[CTL_RUN]              = cfg_run;
        ctl_word[CTL_WIDE]             = cfg_wide;
        ctl_word[CTL_TOEN]             = cfg_timeout_en;
        ctl_word[FLG_BASE +: N_FLAGS]  = flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout_q <= '0;
        else if (rd_go) dout_q <= host_sel ? rd_word : ctl_word;
    end

    assign host_doe  = drive;
    assign host_dout = drive ? dout_q : '0;
    assign host_full = tx_valid || rx_pend;
    assign host_err  = |flags;

endmodule

// File: rtl/strobe_reg_if_chk.sv
`timescale 1ns/1ps
module strobe_reg_if_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rw,
    input logic host_sel,
    input logic host_stb,
    input logic host_doe,
    input logic host_full,
    input logic host_err,
    input logic tx_valid,
    input logic rx_valid,
    input logic ev_sync_err,
    input logic cfg_run
);

    a_r6_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_doe) |-> ($past(host_stb) && $past(host_rw)));

    a_r6_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
        (host_doe && !host_stb) |=> !host_doe);

    a_r3_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> ($past(host_stb) && !$past(host_rw) && $past(host_sel)));

    a_r3_tx_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> host_full);

    a_r5_rx_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_run) |=> host_full);

    a_r8_sync_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sync_err && cfg_run) |=> host_err);

    a_r9_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> (!host_full && !host_err));

endmodule

bind strobe_reg_if strobe_reg_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rw     (host_rw),
    .host_sel    (host_sel),
    .host_stb    (host_stb),
    .host_doe    (host_doe),
    .host_full   (host_full),
    .host_err    (host_err),
    .tx_valid    (tx_valid),
    .rx_valid    (rx_valid),
    .ev_sync_err (ev_sync_err),
    .cfg_run     (cfg_run)
);

// File: tb/strobe_reg_if_tb.sv
`timescale 1ns/1ps
module strobe_reg_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rw = 1'b0, host_sel = 1'b0, host_stb = 1'b0;
    logic [31:0] host_din = '0;
    logic [31:0] host_dout;
    logic        host_doe, host_full, host_err;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_valid = 1'b0;
    logic        ev_sync_err = 1'b0, ev_word_miss = 1'b0;
    logic        cfg_run, cfg_wide, cfg_timeout_en;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        doe_prev = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    strobe_reg_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_rw(host_rw), .host_sel(host_sel),
        .host_stb(host_stb), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .host_full(host_full), .host_err(host_err),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_word(rx_word), .rx_valid(rx_valid), .ev_sync_err(ev_sync_err),
        .ev_word_miss(ev_word_miss), .cfg_run(cfg_run), .cfg_wide(cfg_wide),
        .cfg_timeout_en(cfg_timeout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each read as the bus drive begins
    always @(negedge clk) begin
        if (host_doe && !doe_prev) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected drive", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), host_dout, exp_q.pop_front());
            end
        end
        doe_prev <= host_doe;
    end

    task automatic access(input logic rw, input logic sel, input logic [31:0] d, input int hold);
        @(negedge clk);
        host_rw = rw; host_sel = sel; host_din = d; host_stb = 1'b1;
        repeat (hold) @(negedge clk);
        host_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b1, sel, 32'h0, 1);
    endtask

    task automatic rx_push(input logic [31:0] w);
        @(negedge clk);
        rx_word = w; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 full", {31'b0, host_full}, 32'h0);
        chk("R1 err", {31'b0, host_err}, 32'h0);
        chk("R1 doe", {31'b0, host_doe}, 32'h0);
        chk("R1 cfg", {29'b0, cfg_timeout_en, cfg_wide, cfg_run}, 32'h0);
        rd(1'b0, 32'h0, "R1 ctrl read");

        // R2 control write
        access(1'b0, 1'b0, 32'hFFFF_FFF7, 1);
        chk("R2 cfg", {29'b0, cfg_timeout_en, cfg_wide, cfg_run}, 32'h7);
        rd(1'b0, 32'h7, "R2 ctrl read");

        // R3 data write then take, R6 no drive during write
        @(negedge clk);
        host_rw = 1'b0; host_sel = 1'b1; host_din = 32'hDEAD_BEEF; host_stb = 1'b1;
        @(negedge clk);
        chk("R6 no drive on write", {31'b0, host_doe}, 32'h0);
        chk("R3 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R3 full", {31'b0, host_full}, 32'h1);
        chk("R3 tx_word", tx_word, 32'hDEAD_BEEF);
        // R11 take during held strobe must not re-queue
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
        @(negedge clk);
        chk("R11 held strobe", {31'b0, tx_valid}, 32'h0);
        chk("R3 full after take", {31'b0, host_full}, 32'h0);
        host_stb = 1'b0;
        @(negedge clk);

        // R5 receive and read
        rx_push(32'h1234_5678);
        chk("R5 full", {31'b0, host_full}, 32'h1);
        rd(1'b1, 32'h1234_5678, "R5 data read");
        chk("R5 full cleared", {31'b0, host_full}, 32'h0);

        // R10 arrival coinciding with read
        rx_push(32'hAAAA_0001);
        exp_q.push_back(32'hAAAA_0001);
        tag_q.push_back("R10 older word");
        @(negedge clk);
        rx_word = 32'hBBBB_0002; rx_valid = 1'b1;
        host_rw = 1'b1; host_sel = 1'b1; host_stb = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; host_stb = 1'b0;
        chk("R10 full kept", {31'b0, host_full}, 32'h1);
        @(negedge clk);
        rd(1'b1, 32'hBBBB_0002, "R10 newer word");
        rd(1'b0, 32'h7, "R10 no overwrite");

        // R7 overwrite
        rx_push(32'hCCCC_0003);
        rx_push(32'hDDDD_0004);
        @(negedge clk);
        chk("R7 err", {31'b0, host_err}, 32'h1);
        rd(1'b0, 32'h17, "R7 flag bit4");
        rd(1'b1, 32'hDDDD_0004, "R7 latest word");

        // R9 clear wipes flags
        access(1'b0, 1'b0, 32'hFFFF_FFF6, 1);
        @(negedge clk);
        chk("R9 err cleared", {31'b0, host_err}, 32'h0);
        access(1'b0, 1'b1, 32'h5555_0000, 1);
        chk("R9 write ignored", {31'b0, tx_valid}, 32'h0);
        rx_push(32'hEEEE_0005);
        @(negedge clk);
        chk("R9 rx ignored", {31'b0, host_full}, 32'h0);
        @(negedge clk);
        ev_sync_err = 1'b1;
        @(negedge clk);
        ev_sync_err = 1'b0;
        @(negedge clk);
        chk("R9 event ignored", {31'b0, host_err}, 32'h0);
        rd(1'b0, 32'h6, "R9 ctrl read");

        // R8 error events
        access(1'b0, 1'b0, 32'hFFFF_FFF7, 1);
        @(negedge clk);
        ev_sync_err = 1'b1;
        @(negedge clk);
        ev_sync_err = 1'b0;
        chk("R8 err sync", {31'b0, host_err}, 32'h1);
        rd(1'b0, 32'h47, "R8 bit6");
        @(negedge clk);
        ev_word_miss = 1'b1;
        @(negedge clk);
        ev_word_miss = 1'b0;
        rd(1'b0, 32'h67, "R8 bit5");

        // R4 narrow mode
        access(1'b0, 1'b0, 32'hFFFF_FFF5, 1);
        chk("R4 cfg_wide", {31'b0, cfg_wide}, 32'h0);
        access(1'b0, 1'b1, 32'hAAAA_5555, 1);
        chk("R4 tx narrow", tx_word, 32'h0000_5555);
        rx_push(32'h9999_CCCC);
        rd(1'b1, 32'h0000_CCCC, "R4 rx narrow");

        repeat (4) @(negedge clk);
        chk("R6 all reads seen", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule